// File: doc/BRIEF.md
# Blank-Aligned Frame Capture Controller

This block decides when incoming video pixels are written into a frame store, and which source the display shows. A host sets a one-bit acquire request and a one-bit stored-view select through a write-only control port. The controller waits for the end of the next vertical blank after the request. It then captures one field into the even lines of the store and the following field into the odd lines, so one interlaced frame fills the whole store. For every accepted pixel it produces a frame-store write address, data and enable.

The control register cannot be read back. The host watches progress only through a polled status byte. Bit 0 of that byte carries the vertical blank flag, so software can find the start of a blank by waiting for the bit to go low and then high. Bit 1 shows that a capture is under way. Bit 7 is always zero, so the byte never reads as all ones. An all-ones byte is reserved to mean that no device answers. The stored-view bit selects live video (0) or frame-store contents (1) for the display path.

Top module: `frame_acq_ctrl`

## Requirements
- R1: During and right after reset, fs_we, fs_addr, fs_data, disp_stored and status are all zero, and the acquire and stored-view control bits are clear.
- R2: status[0] equals the vertical blank level sampled at the previous clock edge, active high. status[7:2] are always zero.
- R3: A control write with cfg_acquire=1 while no capture is pending arms the controller. No frame-store write occurs until a vertical blank has ended after arming.
- R4: disp_stored takes the value of cfg_show_stored on the cycle after a control write (0 = live video, 1 = stored frame), and holds it otherwise.
- R5: In the first captured field, each pixel with pix_valid high and vblank low gives fs_we=1 one cycle later. fs_data is that pixel and fs_addr = (2*line)*2^COL_W + column, with line and column counted from zero at the field start. Each line holds 2^COL_W pixels.
- R6: The second field begins at the end of the next vertical blank and writes odd lines, with fs_addr = (2*line+1)*2^COL_W + column. The capture ends when the vertical blank after that field begins.
- R7: status[1] is 1 from the cycle after the blank end that starts the first field until the cycle after the blank start that ends the second field, including the blank between the two fields.
- R8: If acquire is cleared during the first field, that field still completes, the second field is not captured, and status[1] falls when the first field ends.
- R9: Pixels that arrive while vblank is high, and pixels beyond 2^LINE_W lines in a field, are not written.
- R10: When a capture has completed, a still-set acquire bit does not start another capture. Only a new control write with cfg_acquire=1 arms again.
- R11: Clearing acquire while armed, before the blank ends, cancels the capture without any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | Vertical blank, polarity set by VB_ACTIVE_HIGH |
| pix_valid | input | 1 | Incoming pixel strobe |
| pix_data | input | PIX_W | Incoming pixel value |
| cfg_we | input | 1 | Control register write strobe |
| cfg_acquire | input | 1 | Acquire request bit written on cfg_we |
| cfg_show_stored | input | 1 | Stored-view bit written on cfg_we |
| fs_we | output | 1 | Frame-store write enable |
| fs_addr | output | LINE_W+1+COL_W | Frame-store write address |
| fs_data | output | PIX_W | Frame-store write data |
| disp_stored | output | 1 | Display source: 0 live, 1 stored |
| status | output | 8 | Status byte: bit 0 blank, bit 1 acquiring, others zero |

## Verification
Every result of this block is due exactly one clock after the edge that samples its cause. A frame-store write follows its pixel by one cycle. The blank flag follows the vblank level by one cycle. The acquiring flag changes one cycle after the blank edge that opens or closes a capture. The display select follows a control write by one cycle. A behavioural model in the bench advances at each rising edge using the inputs the bench drove at the preceding falling edge. Its predicted outputs are compared with the design at the next falling edge, so each check lands in the one cycle where the result must be present. Per-scenario write tallies then confirm the even-line, odd-line, abort and cancel cases.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
   typedef enum logic [2:0] {
      FG_IDLE   = 3'd0,
      FG_ARMED  = 3'd1,
      FG_FIELD0 = 3'd2,
      FG_GAP    = 3'd3,
      FG_FIELD1 = 3'd4
   } fg_state_t;
endpackage

// File: rtl/fgc_vb_edge.sv
module fgc_vb_edge #(
   parameter bit VB_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vblank_in,
   output logic blank,
   output logic blank_q,
   output logic blank_starts,
   output logic blank_ends
);
   generate
      if (VB_ACTIVE_HIGH) begin : g_pos
         assign blank = vblank_in;
      end else begin : g_neg
         assign blank = ~vblank_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) blank_q <= 1'b0;
      else        blank_q <= blank;
   end

   assign blank_starts = blank & ~blank_q;
   assign blank_ends   = ~blank & blank_q;
endmodule

// File: rtl/fgc_seq.sv
module fgc_seq
   import fgc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_we,
   input  logic      cfg_acquire,
   input  logic      blank_starts,
   input  logic      blank_ends,
   output fg_state_t state,
   output logic      field_start,
   output logic      capturing,
   output logic      odd_field,
   output logic      acquiring
);
   fg_state_t nxt;
   logic      acq_r;

   always_comb begin
      nxt = state;
      unique case (state)
         FG_IDLE:   if (cfg_we && cfg_acquire) nxt = FG_ARMED;
         FG_ARMED:  if (!acq_r) nxt = FG_IDLE;
                    else if (blank_ends) nxt = FG_FIELD0;
         FG_FIELD0: if (blank_starts) nxt = acq_r ? FG_GAP : FG_IDLE;
         FG_GAP:    if (blank_ends) nxt = acq_r ? FG_FIELD1 : FG_IDLE;
         FG_FIELD1: if (blank_starts) nxt = FG_IDLE;
         default:   nxt = FG_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= FG_IDLE;
         acq_r <= 1'b0;
      end else begin
         state <= nxt;
         if (cfg_we) acq_r <= cfg_acquire;
      end
   end

   assign field_start = (nxt != state) && ((nxt == FG_FIELD0) || (nxt == FG_FIELD1));
   assign capturing   = (state == FG_FIELD0) || (state == FG_FIELD1);
   assign odd_field   = (state == FG_FIELD1);
   assign acquiring   = capturing || (state == FG_GAP);
endmodule

// File: rtl/fgc_addr.sv
module fgc_addr #(
   parameter int PIX_W  = 8,
   parameter int COL_W  = 9,
   parameter int LINE_W = 8,
   localparam int ADDR_W = LINE_W + 1 + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              capturing,
   input  logic              odd_field,
   input  logic              blank,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [PIX_W-1:0]  wr_data
);
   logic [COL_W-1:0] col;
   logic [LINE_W:0]  line;
   logic             accept;

   assign accept = capturing && pix_valid && !blank && !line[LINE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col     <= '0;
         line    <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= accept;
         if (field_start) begin
            col  <= '0;
            line <= '0;
         end else if (accept) begin
            wr_addr <= {line[LINE_W-1:0], odd_field, col};
            wr_data <= pix_data;
            col     <= col + 1'b1;
            if (&col) line <= line + 1'b1;
         end
      end
   end
endmodule

// File: rtl/frame_acq_ctrl.sv
module frame_acq_ctrl
   import fgc_pkg::*;
#(
   parameter int PIX_W          = 8,
   parameter int COL_W          = 9,
   parameter int LINE_W         = 8,
   parameter bit VB_ACTIVE_HIGH = 1'b1,
   localparam int ADDR_W        = LINE_W + 1 + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vblank,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   input  logic              cfg_we,
   input  logic              cfg_acquire,
   input  logic              cfg_show_stored,
   output logic              fs_we,
   output logic [ADDR_W-1:0] fs_addr,
   output logic [PIX_W-1:0]  fs_data,
   output logic              disp_stored,
   output logic [7:0]        status
);
   generate
      if (COL_W < 1 || LINE_W < 1 || PIX_W < 1) begin : g_bad_params
         $error("frame_acq_ctrl: all widths must be at least one");
      end
   endgenerate

   logic      blank, blank_q, blank_starts, blank_ends;
   fg_state_t state;
   logic      field_start, capturing, odd_field, acquiring;

   fgc_vb_edge #(.VB_ACTIVE_HIGH(VB_ACTIVE_HIGH)) u_edge (
      .clk          (clk),
      .rst_n        (rst_n),
      .vblank_in    (vblank),
      .blank        (blank),
      .blank_q      (blank_q),
      .blank_starts (blank_starts),
      .blank_ends   (blank_ends)
   );

   fgc_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_acquire  (cfg_acquire),
      .blank_starts (blank_starts),
      .blank_ends   (blank_ends),
      .state        (state),
      .field_start  (field_start),
      .capturing    (capturing),
      .odd_field    (odd_field),
      .acquiring    (acquiring)
   );

   fgc_addr #(.PIX_W(PIX_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_start (field_start),
      .capturing   (capturing),
      .odd_field   (odd_field),
      .blank       (blank),
      .pix_valid   (pix_valid),
      .pix_data    (pix_data),
      .wr_en       (fs_we),
      .wr_addr     (fs_addr),
      .wr_data     (fs_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      disp_stored <= 1'b0;
      else if (cfg_we) disp_stored <= cfg_show_stored;
   end

   assign status = {6'b000000, acquiring, blank_q};
endmodule

// File: rtl/frame_acq_ctrl_chk.sv
module frame_acq_ctrl_chk #(
   parameter bit VB_ACTIVE_HIGH = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       vblank,
   input logic       cfg_we,
   input logic       cfg_show_stored,
   input logic       fs_we,
   input logic       disp_stored,
   input logic [7:0] status
);
   AST_TOP_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] == 1'b0); // R2

   AST_BLANK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status[0] == (VB_ACTIVE_HIGH ? $past(vblank) : !$past(vblank)))); // R2

   AST_DISP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (disp_stored == $past(cfg_show_stored))); // R4

   AST_START_ON_BLANK_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> $fell(status[0])); // R3

   AST_STOP_ON_BLANK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[1]) |-> (status[0] != $past(status[0]))); // R7

   AST_WRITE_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      fs_we |-> $past(status[1])); // R7
endmodule

bind frame_acq_ctrl frame_acq_ctrl_chk #(.VB_ACTIVE_HIGH(VB_ACTIVE_HIGH)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .vblank          (vblank),
   .cfg_we          (cfg_we),
   .cfg_show_stored (cfg_show_stored),
   .fs_we           (fs_we),
   .disp_stored     (disp_stored),
   .status          (status)
);

// File: tb/frame_acq_ctrl_test.sv
`timescale 1ns/1ps
module frame_acq_ctrl_test;
   localparam int PIX_W  = 8;
   localparam int COL_W  = 3;
   localparam int LINE_W = 2;
   localparam int ADDR_W = LINE_W + 1 + COL_W;
   localparam int COLS   = 1 << COL_W;
   localparam int LPF    = 1 << LINE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              vblank = 1'b0;
   logic              pix_valid = 1'b0;
   logic [PIX_W-1:0]  pix_data = '0;
   logic              cfg_we = 1'b0;
   logic              cfg_acquire = 1'b0;
   logic              cfg_show_stored = 1'b0;
   logic              fs_we;
   logic [ADDR_W-1:0] fs_addr;
   logic [PIX_W-1:0]  fs_data;
   logic              disp_stored;
   logic [7:0]        status;

   always #10 clk = ~clk;

   frame_acq_ctrl #(.PIX_W(PIX_W), .COL_W(COL_W), .LINE_W(LINE_W)) uut (
      .clk(clk), .rst_n(rst_n), .vblank(vblank), .pix_valid(pix_valid),
      .pix_data(pix_data), .cfg_we(cfg_we), .cfg_acquire(cfg_acquire),
      .cfg_show_stored(cfg_show_stored), .fs_we(fs_we), .fs_addr(fs_addr),
      .fs_data(fs_data), .disp_stored(disp_stored), .status(status)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int wcount = 0;
   int wodd   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 idle, 4 armed, 1 first field, 2 between, 3 second field
   int   m_ph, m_col, m_ln;
   bit   m_acq, m_vbq;
   logic e_we;
   int   e_addr, e_data;
   bit   e_disp;
   logic [7:0] e_stat;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_col = 0; m_ln = 0; m_acq = 0; m_vbq = 0;
         e_we = 0; e_addr = 0; e_data = 0; e_disp = 0; e_stat = 8'h00;
      end else begin
         bit fall, rise;
         fall = m_vbq && !vblank;
         rise = !m_vbq && vblank;
         e_we = (m_ph == 1 || m_ph == 3) && pix_valid && !vblank && (m_ln < LPF);
         if (e_we) begin
            e_addr = (2 * m_ln + ((m_ph == 3) ? 1 : 0)) * COLS + m_col;
            e_data = int'(pix_data);
            m_col++;
            if (m_col == COLS) begin m_col = 0; m_ln++; end
         end
         case (m_ph)
            0: if (cfg_we && cfg_acquire) m_ph = 4;
            4: if (!m_acq) m_ph = 0;
               else if (fall) begin m_ph = 1; m_col = 0; m_ln = 0; end
            1: if (rise) m_ph = m_acq ? 2 : 0;
            2: if (fall) begin
                  if (m_acq) begin m_ph = 3; m_col = 0; m_ln = 0; end
                  else m_ph = 0;
               end
            3: if (rise) m_ph = 0;
            default: m_ph = 0;
         endcase
         if (cfg_we) begin m_acq = cfg_acquire; e_disp = cfg_show_stored; end
         e_stat = {6'b0, (m_ph == 1 || m_ph == 2 || m_ph == 3), vblank};
         m_vbq = vblank;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk(fs_we === e_we, "R5 write enable", int'(fs_we), int'(e_we));
         if (e_we) begin
            chk(int'(fs_addr) == e_addr, (e_addr / COLS) % 2 ? "R6 odd address" : "R5 even address",
                int'(fs_addr), e_addr);
            chk(int'(fs_data) == e_data, "R5 data", int'(fs_data), e_data);
         end
         chk(status === e_stat, "R2 R7 status", int'(status), int'(e_stat));
         chk(disp_stored === e_disp, "R4 display select", int'(disp_stored), int'(e_disp));
         if (fs_we) begin
            wcount++;
            if ((int'(fs_addr) / COLS) % 2 == 1) wodd++;
         end
      end
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   int pix_seed = 8'h11;

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); pix_valid = 0; end
   endtask

   task automatic blank(input int n);
      repeat (n) begin @(negedge clk); vblank = 1; pix_valid = 1; pix_data = 8'hEE; end
   endtask

   task automatic active(input int lines);
      for (int l = 0; l < lines; l++) begin
         @(negedge clk); vblank = 0; pix_valid = 0;
         for (int c = 0; c < COLS; c++) begin
            @(negedge clk);
            pix_valid = 1;
            pix_seed  = (pix_seed * 5 + 3) % 256;
            pix_data  = 8'(pix_seed);
         end
      end
      @(negedge clk); pix_valid = 0;
   endtask

   task automatic cfg(input bit acq, input bit show);
      @(negedge clk); cfg_we = 1; cfg_acquire = acq; cfg_show_stored = show;
      @(negedge clk); cfg_we = 0;
   endtask

   initial begin
      idle(3);
      chk(fs_we == 0 && fs_addr == 0 && fs_data == 0, "R1 reset write port", int'(fs_we), 0);
      chk(disp_stored == 0 && status == 0, "R1 reset status", int'(status), 0);
      @(negedge clk); rst_n = 1;

      // no arm: video passes, nothing written
      active(2); blank(3); active(2);
      chk(wcount == 0, "R3 no write unarmed", wcount, 0);

      cfg(0, 1);
      @(negedge clk);
      chk(disp_stored == 1, "R4 stored view", int'(disp_stored), 1);
      cfg(0, 0);
      @(negedge clk);
      chk(disp_stored == 0, "R4 live view", int'(disp_stored), 0);

      // arm mid-active, must wait for the next blank end
      active(1);
      wcount = 0; wodd = 0;
      cfg(1, 0);
      active(2);
      chk(wcount == 0, "R3 armed waits for blank end", wcount, 0);
      blank(2);
      @(negedge clk);
      chk(status[0] == 1, "R2 blank flag", int'(status[0]), 1);
      chk(status[1] == 0, "R7 not acquiring while armed", int'(status[1]), 0);
      active(LPF + 1);
      chk(status[1] == 1, "R7 acquiring in first field", int'(status[1]), 1);
      blank(3);
      chk(wcount == LPF * COLS && wodd == 0, "R5 R9 first field even lines", wcount, LPF * COLS);
      chk(status[1] == 1, "R7 acquiring between fields", int'(status[1]), 1);
      active(LPF);
      blank(3);
      chk(wcount == 2 * LPF * COLS, "R6 full frame writes", wcount, 2 * LPF * COLS);
      chk(wodd == LPF * COLS, "R6 odd lines filled", wodd, LPF * COLS);
      chk(status[1] == 0, "R7 acquiring cleared after second field", int'(status[1]), 0);

      // acquire still set: no new capture
      active(LPF); blank(3); active(LPF); blank(3);
      chk(wcount == 2 * LPF * COLS, "R10 no restart", wcount, 2 * LPF * COLS);

      // abort during first field
      cfg(0, 1);
      wcount = 0; wodd = 0;
      cfg(1, 1);
      blank(2);
      active(2);
      cfg(0, 1);
      active(LPF - 2);
      blank(3);
      chk(wcount == LPF * COLS && wodd == 0, "R8 first field completes", wcount, LPF * COLS);
      chk(status[1] == 0, "R8 acquiring drops", int'(status[1]), 0);
      active(LPF); blank(3);
      chk(wodd == 0 && wcount == LPF * COLS, "R8 second field skipped", wodd, 0);

      // arm then cancel before blank end
      wcount = 0;
      cfg(1, 0);
      cfg(0, 0);
      blank(2); active(LPF); blank(2); active(LPF); blank(2);
      chk(wcount == 0, "R11 cancel while armed", wcount, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule